// File: doc/BRIEF.md
# Unlock-Gated Debug Signal Multiplexer

This block lets a transceiver's digital core expose internal debug signals on four shared pins. Each pin normally carries its functional signal. Two 8-bit test registers sit on a simple write bus. Each test register holds a pair of 4-bit select fields, and each field picks one of sixteen debug sources for one pin. A write to a test register counts only when a separate unlock register already holds a fixed key.

An accepted write arms its test register. Routing then stays active until that register is rewritten with an accepted write, or until reset. Changing or clearing the unlock register afterwards does not disable routing that is already armed. Some source codes are not wired to anything. A pin set to such a code drives a constant low. Every pin output is registered once.

Top module: `dbg_route_mux`

## Requirements
- R1: A synchronous active-high reset clears the unlock register, both test registers and both enable flags, and drives every pin low. From the first clock after reset is released, every pin carries its functional input.
- R2: A write to address 0x4A loads the unlock register. A test-register write is accepted only if the unlock register held the key (default 0x5A) before that clock edge.
- R3: A test-register write made while the unlock register does not hold the key is ignored. The stored selection and the enable flag stay unchanged, and so do the pins.
- R4: An accepted write to 0x4B sets its enable flag. Data bits 7:4 then select the source for pin 0 and bits 3:0 the source for pin 1.
- R5: An accepted write to 0x4C sets its enable flag. Data bits 7:4 then select the source for pin 2 and bits 3:0 the source for pin 3.
- R6: An enabled pin p with select code c drives dbg_src[p*16+c]. Each pin is registered, so a pin changes one clock after the input or state change that causes it.
- R7: Once a test register is armed, writing any other value to the unlock register leaves its routing active.
- R8: A later accepted write to an armed test register replaces both of its select fields. The new routing takes effect one clock after the write.
- R9: Source code 13 on pin 0 and source code 2 on pin 3 are unconnected. While enabled with such a code, the pin drives 0 whatever the source input holds.
- R10: The two enable flags are independent. Arming one test register leaves the other register's two pins on their functional inputs.
- R11: A write to any address other than 0x4A, 0x4B or 0x4C changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| dbg_src | input | 64 | Debug sources, 16 per pin, pin p at bits p*16+15:p*16 |
| func_in | input | 4 | Functional signal for each pin |
| pin_out | output | 4 | Registered shared pin outputs |

## Verification
The stored state has no visible output except the pins. A wrong unlock decision, select field or enable flag therefore shows up as a pin that follows the wrong source or its functional input, one clock after the write that caused it. The sources and functional inputs change at random every cycle. Because of this, a wrong selection differs from the expected pin value within a few cycles, and the bench compares every pin on every clock. An armed flag that is lost after the unlock register is cleared falls back to functional mode at once, and the bench sees that fall-back on the next clock.

// File: rtl/dbg_mux_pkg.sv
package dbg_mux_pkg;
    localparam int ADDR_W   = 8;
    localparam int REG_W    = 8;
    localparam int SEL_W    = 4;
    localparam int NUM_SRC  = 1 << SEL_W;
    localparam int NUM_TREG = 2;
    localparam int PINS_PER_TREG = REG_W / SEL_W;
    localparam int NUM_PINS = NUM_TREG * PINS_PER_TREG;

    localparam logic [ADDR_W-1:0] UNLOCK_ADDR    = 8'h4A;
    localparam logic [ADDR_W-1:0] TREG_BASE_ADDR = 8'h4B;

    typedef struct packed {
        logic [SEL_W-1:0] hi;
        logic [SEL_W-1:0] lo;
    } tsel_t;

    function automatic logic [ADDR_W-1:0] treg_addr(input int idx);
        return TREG_BASE_ADDR + ADDR_W'(idx);
    endfunction

    function automatic logic [SEL_W-1:0] field_of(input tsel_t s, input int slot);
        return (slot == 0) ? s.hi : s.lo;
    endfunction
endpackage

// File: rtl/dbg_unlock_reg.sv
module dbg_unlock_reg
    import dbg_mux_pkg::*;
#(
    parameter logic [REG_W-1:0] KEY = 8'h5A
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] unlock_q,
    output logic             armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q <= '0;
        end else if (wr) begin
            unlock_q <= wr_data;
        end
    end

    assign armed = (unlock_q == KEY);
endmodule

// File: rtl/dbg_test_reg.sv
module dbg_test_reg
    import dbg_mux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [REG_W-1:0] wr_data,
    output tsel_t            sel_q,
    output logic             en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            en_q  <= 1'b0;
        end else if (accept) begin
            sel_q <= tsel_t'(wr_data);
            en_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/dbg_pin_sel.sv
module dbg_pin_sel
    import dbg_mux_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] NC_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    input  logic               func,
    output logic               pin
);
    logic nxt;

    always_comb begin
        if (!en) begin
            nxt = func;
        end else if (NC_MASK[sel]) begin
            nxt = 1'b0;
        end else begin
            nxt = src[sel];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else begin
            pin <= nxt;
        end
    end
endmodule

// File: rtl/dbg_route_mux.sv
module dbg_route_mux
    import dbg_mux_pkg::*;
#(
    parameter logic [REG_W-1:0]            UNLOCK_KEY = 8'h5A,
    parameter logic [NUM_PINS*NUM_SRC-1:0] NC_MAP     = 64'h0004_0000_0000_2000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [REG_W-1:0]            wr_data,
    input  logic [NUM_PINS*NUM_SRC-1:0] dbg_src,
    input  logic [NUM_PINS-1:0]         func_in,
    output logic [NUM_PINS-1:0]         pin_out
);
    logic [REG_W-1:0]    unlock_q;
    logic                armed;
    tsel_t [NUM_TREG-1:0] test_q;
    logic [NUM_TREG-1:0] en_q;

    dbg_unlock_reg #(.KEY(UNLOCK_KEY)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_en && (wr_addr == UNLOCK_ADDR)),
        .wr_data  (wr_data),
        .unlock_q (unlock_q),
        .armed    (armed)
    );

    for (genvar r = 0; r < NUM_TREG; r++) begin : g_treg
        logic accept;
        assign accept = wr_en && armed && (wr_addr == treg_addr(r));

        dbg_test_reg u_treg (
            .clk     (clk),
            .rst     (rst),
            .accept  (accept),
            .wr_data (wr_data),
            .sel_q   (test_q[r]),
            .en_q    (en_q[r])
        );
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int RIDX = p / PINS_PER_TREG;
        localparam int SLOT = p % PINS_PER_TREG;
        logic [SEL_W-1:0] sel_w;
        assign sel_w = field_of(test_q[RIDX], SLOT);

        dbg_pin_sel #(.NC_MASK(NC_MAP[p*NUM_SRC +: NUM_SRC])) u_pin (
            .clk  (clk),
            .rst  (rst),
            .en   (en_q[RIDX]),
            .sel  (sel_w),
            .src  (dbg_src[p*NUM_SRC +: NUM_SRC]),
            .func (func_in[p]),
            .pin  (pin_out[p])
        );
    end
endmodule

// File: rtl/dbg_route_chk.sv
module dbg_route_chk #(
    parameter logic [7:0]  KEY    = 8'h5A,
    parameter logic [63:0] NC_MAP = 64'h0004_0000_0000_2000
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [7:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic [3:0]  func_in,
    input logic [3:0]  pin_out,
    input logic [7:0]  unlock_q,
    input logic [15:0] test_q,
    input logic [1:0]  en_q
);
    AST_LOCKED_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == 8'h4B || wr_addr == 8'h4C) && unlock_q != KEY)
        |=> ($stable(test_q) && $stable(en_q))); // R3

    AST_ACCEPT_A: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 8'h4B && unlock_q == KEY)
        |=> (en_q[0] && test_q[7:0] == $past(wr_data))); // R4

    AST_ACCEPT_B: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 8'h4C && unlock_q == KEY)
        |=> (en_q[1] && test_q[15:8] == $past(wr_data))); // R5

    AST_ARMED_STAYS: assert property (@(posedge clk) disable iff (rst)
        (en_q == 2'b11) |=> (en_q == 2'b11)); // R7

    AST_IDLE_A_FUNC: assert property (@(posedge clk) disable iff (rst)
        !en_q[0] |=> (pin_out[1:0] == $past(func_in[1:0]))); // R10

    AST_IDLE_B_FUNC: assert property (@(posedge clk) disable iff (rst)
        !en_q[1] |=> (pin_out[3:2] == $past(func_in[3:2]))); // R10

    AST_NC_PIN0_LOW: assert property (@(posedge clk) disable iff (rst)
        (en_q[0] && NC_MAP[{2'd0, test_q[7:4]}]) |=> !pin_out[0]); // R9

    AST_NC_PIN3_LOW: assert property (@(posedge clk) disable iff (rst)
        (en_q[1] && NC_MAP[{2'd3, test_q[11:8]}]) |=> !pin_out[3]); // R9

    AST_OTHER_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != 8'h4A && wr_addr != 8'h4B && wr_addr != 8'h4C)
        |=> ($stable(unlock_q) && $stable(test_q) && $stable(en_q))); // R11
endmodule

bind dbg_route_mux dbg_route_chk #(.KEY(UNLOCK_KEY), .NC_MAP(NC_MAP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .func_in  (func_in),
    .pin_out  (pin_out),
    .unlock_q (unlock_q),
    .test_q   (test_q),
    .en_q     (en_q)
);

// File: tb/test_dbg_route_mux.sv
`timescale 1ns/1ps
module test_dbg_route_mux;
    localparam logic [7:0] KEY = 8'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [63:0] dbg_src = '0;
    logic [3:0]  func_in = '0;
    logic [3:0]  pin_out;

    dbg_route_mux i_dbg_route_mux (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dbg_src (dbg_src),
        .func_in (func_in),
        .pin_out (pin_out)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    bit    started  = 0;
    bit    ones     = 0;
    bit    done     = 0;
    string tag      = "R1";

    // behavioural reference state
    logic [7:0] unlock_m;
    int         sel_m [4];
    bit         en_m  [2];
    logic [3:0] exp_m;

    task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: pin_out actual %b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            unlock_m = '0;
            for (int i = 0; i < 4; i++) sel_m[i] = 0;
            en_m[0] = 0;
            en_m[1] = 0;
            exp_m = '0;
        end else begin
            for (int p = 0; p < 4; p++) begin
                if (!en_m[p/2]) exp_m[p] = func_in[p];
                else if ((p == 0 && sel_m[p] == 13) || (p == 3 && sel_m[p] == 2)) exp_m[p] = 1'b0;
                else exp_m[p] = dbg_src[p*16 + sel_m[p]];
            end
            if (wr_en) begin
                if (wr_addr == 8'h4A) unlock_m = wr_data;
                else if (wr_addr == 8'h4B && unlock_m == KEY) begin
                    sel_m[0] = int'(wr_data[7:4]);
                    sel_m[1] = int'(wr_data[3:0]);
                    en_m[0]  = 1;
                end else if (wr_addr == 8'h4C && unlock_m == KEY) begin
                    sel_m[2] = int'(wr_data[7:4]);
                    sel_m[3] = int'(wr_data[3:0]);
                    en_m[1]  = 1;
                end
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) check(pin_out === exp_m, tag, pin_out, exp_m);
        dbg_src = ones ? '1 : {$urandom, $urandom};
        func_in = 4'($urandom);
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        tag = "R1"; rst = 1'b1;
        idle(3);
        rst = 1'b0;
        tag = "R1 R6";
        idle(10);
        tag = "R3";
        wr(8'h4B, 8'h12);
        wr(8'h4C, 8'h34);
        idle(5);
        tag = "R11";
        wr(8'h4D, KEY);
        wr(8'h00, KEY);
        wr(8'h4B, 8'h34);
        idle(4);
        tag = "R2";
        wr(8'h4A, KEY ^ 8'h01);
        wr(8'h4B, 8'h56);
        idle(4);
        wr(8'h4A, KEY);
        tag = "R4 R10";
        wr(8'h4B, 8'h37);
        idle(12);
        tag = "R5";
        wr(8'h4C, 8'hE9);
        idle(12);
        tag = "R11";
        wr(8'hFF, 8'h00);
        wr(8'h4E, 8'h11);
        idle(4);
        tag = "R7";
        wr(8'h4A, 8'h00);
        idle(8);
        tag = "R3";
        wr(8'h4B, 8'hFF);
        wr(8'h4C, 8'hFF);
        idle(4);
        tag = "R8";
        wr(8'h4A, KEY);
        for (int c = 0; c < 16; c++) begin
            wr(8'h4B, {4'(c), 4'(15 - c)});
            wr(8'h4C, {4'(15 - c), 4'(c)});
            idle(3);
        end
        tag = "R9";
        ones = 1;
        wr(8'h4B, 8'hD0);
        wr(8'h4C, 8'h02);
        idle(6);
        ones = 0;
        idle(2);
        tag = "R1";
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        wr(8'h4B, 8'h55);
        idle(6);
        finish_run();
    end
endmodule